// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word of a 10/100 Ethernet PHY and turns it into the PHY's control outputs. An upstream management decoder presents a write strobe with a 16-bit data word. The current register value is always visible on the read port. The bits drive the following outputs:

- a soft reset request, held until the PCS reports that its reset is complete;
- internal loopback;
- the effective speed and duplex, taken from the register when auto-negotiation is off and from the negotiation result when it is on;
- auto-negotiation enable and a restart request, held until the negotiation engine acknowledges it;
- power-down, merged with an active-low pin;
- isolate.

A collision test mode raises COL a fixed number of bit times after the transmit enable rises. It drops COL on the first clock after the transmit enable falls. Bit times are measured with a clock divider, and the effective speed picks its ratio.

Top module: `phy_basic_ctl`

## Requirements
- R1: After hard reset the read port shows 0x3100 when `strapAnegOff` is 0 and 0x2100 when it is 1. This means speed 100 (bit 13), auto-negotiation on (bit 12, inverted strap) and full duplex (bit 8), with every other bit 0.
- R2: A write with bit 15 set stores the word and raises bit 15 and `softRst` from the next cycle. Both stay high, and further writes are ignored, until `resetDone` is sampled high. On the clock that samples `resetDone` high, the register returns to the R1 default for the current strap value and `softRst` falls.
- R3: Bits 14 (loopback), 12 (auto-negotiation enable), 10 (isolate), 13 (speed), 8 (duplex) and 7 (collision test) read back as last written. Bits 14, 12 and 10 drive `loopbackEn`, `anegEn` and `isolate`.
- R4: When bit 12 is 0, `speed100` equals bit 13 and `fullDuplex` equals bit 8. When bit 12 is 1, they follow `negSpeed100` and `negFullDuplex`.
- R5: Writing bit 9 as 1 together with bit 12 as 1 sets the restart bit and `anegRestart`. The bit clears on the cycle after `anegStartAck` is sampled high. Writing bit 9 as 0 does not clear it. Any write with bit 12 as 0 leaves it at 0.
- R6: `powerDown` is bit 11 OR the inverted `pwrDownPinN`. While the pin is low, bit 11 is set on every clock and cannot be written to 0. The bit stays set after the pin is released, until it is written to 0.
- R7: Bits 6 to 0 read as 0 whatever is written.
- R8: With bit 7 at 1 and `txEn` held high, `col` rises exactly COL_BITS×DIV clock edges after `txEn` is first sampled high. DIV is FAST_DIV at effective 100 Mbps and SLOW_DIV at 10 Mbps. `col` falls on the first edge that samples `txEn` low. With bit 7 at 0, `col` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Current register value |
| strapAnegOff | input | 1 | Strap: 1 makes auto-negotiation default to off |
| pwrDownPinN | input | 1 | Active-low power-down pin |
| resetDone | input | 1 | PCS soft reset complete |
| anegStartAck | input | 1 | Negotiation engine accepted the restart |
| negSpeed100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| negFullDuplex | input | 1 | Negotiated duplex, 1 = full |
| txEn | input | 1 | Transmit enable |
| softRst | output | 1 | PCS soft reset request |
| loopbackEn | output | 1 | Internal loopback enable |
| speed100 | output | 1 | Effective speed, 1 = 100 Mbps |
| fullDuplex | output | 1 | Effective duplex, 1 = full |
| anegEn | output | 1 | Auto-negotiation enable |
| anegRestart | output | 1 | Auto-negotiation restart request |
| powerDown | output | 1 | Effective power-down |
| isolate | output | 1 | Isolate data interface |
| col | output | 1 | Test collision signal |

## Verification
The bench sweeps all 32 combinations of the loopback, speed, auto-negotiation, isolate and duplex bits, each against all four negotiated speed and duplex values. This separates the register path from the negotiated path for speed and duplex. The restart bit is driven through a set, an attempted clear by writing 0, an acknowledge, and writes with auto-negotiation off. Together these show which event clears it. Soft reset is tried under both strap values with writes during the reset, and power-down is tried with the pin low during a clearing write. The collision test is timed edge by edge at both speeds and with the test bit off, so an off-by-one in the divider or in the bit counter shows up.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;

  // Field order matches the read-back bit positions 15 down to 7.
  typedef struct packed {
    logic rst;
    logic loop;
    logic spd;
    logic an;
    logic pd;
    logic iso;
    logic restart;
    logic dup;
    logic colTest;
  } ctlRegT;

  // Strobes from the control half to the collision-test datapath.
  typedef struct packed {
    logic colTestEn;
    logic fastBit;
  } dpStrobeT;

endpackage

// File: rtl/phyctl_regs.sv
module phyctl_regs
  import phyctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        strapAnegOff,
  input  logic        pwrDownPinN,
  input  logic        resetDone,
  input  logic        anegStartAck,
  input  logic        negSpeed100,
  input  logic        negFullDuplex,
  output logic [15:0] rdData,
  output dpStrobeT    strobe,
  output logic        softRst,
  output logic        loopbackEn,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        anegEn,
  output logic        anegRestart,
  output logic        powerDown,
  output logic        isolate
);

  ctlRegT ctl;
  ctlRegT dflt;

  always_comb begin
    dflt         = '0;
    dflt.spd     = 1'b1;
    dflt.an      = ~strapAnegOff;
    dflt.dup     = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl <= dflt;
    end else begin
      if (ctl.rst) begin
        // reset in progress: writes ignored, restart held
        if (resetDone) ctl <= dflt;
      end else if (wrEn) begin
        ctl.rst     <= wrData[15];
        ctl.loop    <= wrData[14];
        ctl.spd     <= wrData[13];
        ctl.an      <= wrData[12];
        ctl.pd      <= wrData[11];
        ctl.iso     <= wrData[10];
        ctl.restart <= wrData[12] & (wrData[9] | (ctl.restart & ~anegStartAck));
        ctl.dup     <= wrData[8];
        ctl.colTest <= wrData[7];
      end else begin
        ctl.restart <= ctl.restart & ~anegStartAck & ctl.an;
      end
      if (!pwrDownPinN) ctl.pd <= 1'b1;
    end
  end

  assign rdData           = {ctl, 7'b0};
  assign softRst          = ctl.rst;
  assign loopbackEn       = ctl.loop;
  assign anegEn           = ctl.an;
  assign anegRestart      = ctl.restart;
  assign isolate          = ctl.iso;
  assign powerDown        = ctl.pd | ~pwrDownPinN;
  assign speed100         = ctl.an ? negSpeed100 : ctl.spd;
  assign fullDuplex       = ctl.an ? negFullDuplex : ctl.dup;
  assign strobe.colTestEn = ctl.colTest;
  assign strobe.fastBit   = speed100;

endmodule

// File: rtl/phyctl_coltest.sv
module phyctl_coltest
  import phyctl_pkg::*;
#(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 10,
  parameter int COL_BITS = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpStrobeT strobe,
  input  logic     txEn,
  output logic     col
);

  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int CNT_W   = $clog2(COL_BITS + 1);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LIM  = CNT_W'(COL_BITS);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divLim;
  logic             active;
  logic             bitTick;

  assign active  = strobe.colTestEn & txEn;
  assign divLim  = strobe.fastBit ? FAST_LIM : SLOW_LIM;
  assign bitTick = (divCnt == divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!active) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      divCnt <= bitTick ? '0 : divCnt + 1'b1;
      if (bitTick && bitCnt != BIT_LIM) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign col = (bitCnt == BIT_LIM);

endmodule

// File: rtl/phy_basic_ctl.sv
module phy_basic_ctl #(
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 10,
  parameter int COL_BITS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        strapAnegOff,
  input  logic        pwrDownPinN,
  input  logic        resetDone,
  input  logic        anegStartAck,
  input  logic        negSpeed100,
  input  logic        negFullDuplex,
  input  logic        txEn,
  output logic        softRst,
  output logic        loopbackEn,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        anegEn,
  output logic        anegRestart,
  output logic        powerDown,
  output logic        isolate,
  output logic        col
);

  phyctl_pkg::dpStrobeT strobe;

  phyctl_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strapAnegOff(strapAnegOff), .pwrDownPinN(pwrDownPinN),
    .resetDone(resetDone), .anegStartAck(anegStartAck),
    .negSpeed100(negSpeed100), .negFullDuplex(negFullDuplex),
    .rdData(rdData), .strobe(strobe), .softRst(softRst),
    .loopbackEn(loopbackEn), .speed100(speed100), .fullDuplex(fullDuplex),
    .anegEn(anegEn), .anegRestart(anegRestart), .powerDown(powerDown),
    .isolate(isolate)
  );

  phyctl_coltest #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .COL_BITS(COL_BITS)
  ) u_col (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txEn(txEn), .col(col)
  );

endmodule

// File: rtl/phy_basic_ctl_chk.sv
module phy_basic_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        txEn,
  input logic        resetDone,
  input logic        anegStartAck,
  input logic        pwrDownPinN,
  input logic [15:0] rdData,
  input logic        softRst,
  input logic        anegEn,
  input logic        anegRestart,
  input logic        speed100,
  input logic        fullDuplex,
  input logic        powerDown,
  input logic        col
);

  assert_rst_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    softRst && !resetDone |=> softRst && $stable(rdData[15:12]));

  assert_rst_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    softRst && resetDone |=> !softRst && !rdData[14]);

  assert_speed_dup_R4: assert property (@(posedge clk) disable iff (!rstN)
    !anegEn |-> (speed100 == rdData[13]) && (fullDuplex == rdData[8]));

  assert_restart_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    anegRestart && anegStartAck && !wrEn && !softRst |=> !anegRestart);

  assert_restart_needs_an_R5: assert property (@(posedge clk) disable iff (!rstN)
    anegRestart |-> anegEn);

  assert_pd_pin_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownPinN |-> powerDown);

  assert_pd_sets_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownPinN |=> rdData[11]);

  assert_col_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> !col);

  assert_col_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[7] |=> !col);

endmodule

bind phy_basic_ctl phy_basic_ctl_chk u_chk (.*);

// File: tb/sim_phy_basic_ctl.sv
module sim_phy_basic_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int FAST = 2;
  localparam int SLOW = 5;
  localparam int NBITS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        strapAnegOff = 1'b0;
  logic        pwrDownPinN = 1'b1;
  logic        resetDone = 1'b0;
  logic        anegStartAck = 1'b0;
  logic        negSpeed100 = 1'b0;
  logic        negFullDuplex = 1'b0;
  logic        txEn = 1'b0;
  logic        softRst, loopbackEn, speed100, fullDuplex, anegEn;
  logic        anegRestart, powerDown, isolate, col;

  int total = 0;
  int bad = 0;

  phy_basic_ctl #(.FAST_DIV(FAST), .SLOW_DIV(SLOW), .COL_BITS(NBITS)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hardReset(input logic strap);
    @(negedge clk);
    strapAnegOff = strap;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic colRun(input logic [15:0] cfg, input int div, input string req);
    wr(cfg);
    txEn = 1'b1;
    repeat (NBITS*div - 1) @(negedge clk);
    chk({req, " col before"}, {15'b0, col}, 16'h0);
    @(negedge clk);
    chk({req, " col rise"}, {15'b0, col}, 16'h1);
    repeat (3) @(negedge clk);
    chk({req, " col held"}, {15'b0, col}, 16'h1);
    txEn = 1'b0;
    @(negedge clk);
    chk({req, " col fall"}, {15'b0, col}, 16'h0);
  endtask

  initial begin
    // R1: strap-dependent reset value
    hardReset(1'b1);
    chk("R1 strap1", rdData, 16'h2100);
    hardReset(1'b0);
    chk("R1 strap0", rdData, 16'h3100);
    chk("R1 outputs", {12'b0, softRst, powerDown, col, anegRestart}, 16'h0);

    // R7: reserved bits
    wr(16'h007F);
    chk("R7 reserved", rdData, 16'h0000);

    // R3 / R4: sweep of control bits against negotiated values
    for (int i = 0; i < 32; i++) begin
      for (int n = 0; n < 4; n++) begin
        logic [15:0] d;
        logic an;
        d = {1'b0, i[4], i[3], i[2], 1'b0, i[1], 1'b0, i[0], 8'h00};
        an = i[2];
        negSpeed100 = n[1];
        negFullDuplex = n[0];
        wr(d);
        chk("R3 readback", rdData, d);
        chk("R3 outputs", {13'b0, loopbackEn, anegEn, isolate}, {13'b0, i[4], i[2], i[1]});
        chk("R4 eff speed/duplex", {14'b0, speed100, fullDuplex},
            {14'b0, an ? n[1] : i[3], an ? n[0] : i[0]});
      end
    end

    // R5: restart bit
    wr(16'h0000);
    wr(16'h1200);
    chk("R5 set", {15'b0, anegRestart}, 16'h1);
    chk("R5 read", rdData, 16'h1200);
    wr(16'h1000);
    chk("R5 write0 no clear", {15'b0, anegRestart}, 16'h1);
    @(negedge clk);
    anegStartAck = 1'b1;
    @(negedge clk);
    anegStartAck = 1'b0;
    chk("R5 ack clears", rdData, 16'h1000);
    wr(16'h0200);
    chk("R5 ignored when AN off", rdData, 16'h0000);
    wr(16'h1200);
    wr(16'h0000);
    chk("R5 AN off clears", {15'b0, anegRestart}, 16'h0);

    // R6: power-down pin
    @(negedge clk);
    pwrDownPinN = 1'b0;
    #1;
    chk("R6 pin comb", {15'b0, powerDown}, 16'h1);
    @(negedge clk);
    chk("R6 pin sets bit", rdData, 16'h0800);
    pwrDownPinN = 1'b1;
    @(negedge clk);
    chk("R6 sticky", {15'b0, powerDown}, 16'h1);
    wr(16'h0000);
    chk("R6 write clears", {15'b0, powerDown}, 16'h0);
    wr(16'h0800);
    chk("R6 write sets", {15'b0, powerDown}, 16'h1);
    pwrDownPinN = 1'b0;
    wr(16'h0000);
    chk("R6 pin beats write", rdData, 16'h0800);
    pwrDownPinN = 1'b1;
    wr(16'h0000);

    // R8: collision test at both speeds and disabled
    colRun(16'h0080, SLOW, "R8 10M");
    colRun(16'h2080, FAST, "R8 100M");
    wr(16'h2000);
    txEn = 1'b1;
    repeat (NBITS*SLOW + 4) @(negedge clk);
    chk("R8 disabled", {15'b0, col}, 16'h0);
    txEn = 1'b0;

    // R2: soft reset
    wr(16'hC400);
    chk("R2 in progress", rdData, 16'hC400);
    chk("R2 softRst", {14'b0, softRst, loopbackEn}, 16'h3);
    wr(16'h0000);
    chk("R2 write ignored", rdData, 16'hC400);
    repeat (3) @(negedge clk);
    chk("R2 held", {15'b0, softRst}, 16'h1);
    resetDone = 1'b1;
    @(negedge clk);
    resetDone = 1'b0;
    chk("R2 defaults strap0", rdData, 16'h3100);
    chk("R2 released", {13'b0, softRst, loopbackEn, isolate}, 16'h0);
    strapAnegOff = 1'b1;
    wr(16'h8000);
    resetDone = 1'b1;
    @(negedge clk);
    resetDone = 1'b0;
    chk("R2 defaults strap1", rdData, 16'h2100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule